// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a bank of general-purpose I/O ports behind a simple APB-style register interface. Every port has an output value register and a per-pin output-enable (direction) register, and it shows the synchronised state of its input pins in a read-only register. Only the first port can raise interrupts. Each of its pins can be enabled, masked, set to level or edge sensing and given a polarity. Edge events stay latched until a write-one-to-clear acknowledge removes them. The enabled, unmasked pending bits are OR-ed onto a single interrupt line.

Input pins cross into the clock domain through a two-flop synchroniser. For pins of the first port, a per-bit debounce filter can hold off a change until the new value has been seen for a set number of debounce ticks. A static strap input selects an alternate placement of the interrupt registers. The host must emulate both-edge sensing by flipping the polarity after each event.

Top module: `pin_bank_apb`

## Requirements
- R1: After reset every register reads zero. `pinOe` is all zero, so every pin is an input. `irqOut` is low.
- R2: Port k has its output value register at byte address 0x0C·k and its direction register at 0x0C·k+4. Writes land in the register, read back unchanged, and drive `pinOut`/`pinOe` slice k in the next cycle. A direction bit of 1 makes that pin an output.
- R3: Port k's input register at 0x50+4·k returns the pin levels after two clock edges of synchronisation.
- R4: An interrupt type bit of 0 selects level sensing. With polarity 1 the pin is active while high; with polarity 0 it is active while low. The level is not latched and follows the pin.
- R5: An interrupt type bit of 1 selects edge sensing. Polarity 1 catches rising edges and polarity 0 catches falling edges. An event latches only while that pin's enable bit is 1.
- R6: A mask bit of 1 hides its pin from the status register and from `irqOut`, without losing a latched edge. Clearing the mask shows the latched edge again.
- R7: Writing the acknowledge register clears the latched edge of each pin whose written bit is 1. Bits written as 0 have no effect. The acknowledge register reads as zero.
- R8: The status register holds enable AND NOT mask AND pending for each pin, and `irqOut` is the OR of its bits.
- R9: With its debounce bit set, a first-port pin's new level is accepted only after `DEB_TICKS` `dbTick` pulses during which the synchronised input differs from the accepted value. Any return to the accepted value restarts the count.
- R10: Default layout: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, status 0x40, debounce 0x48, acknowledge 0x4C. With `altLayout`=1: mask 0x44, type 0x34, polarity 0x38, status 0x3C, acknowledge 0x40, and the other offsets stay the same.
- R11: Pins of ports other than the first never affect `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| altLayout | input | 1 | Strap: 1 selects the alternate interrupt register placement |
| psel | input | 1 | Register access select |
| penable | input | 1 | Access phase; a write commits when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | PORT_W | Write data |
| prdata | output | PORT_W | Read data, valid while psel is high |
| pinIn | input | NUM_PORTS·PORT_W | Raw pin levels, port k in slice k |
| dbTick | input | 1 | Debounce sampling strobe |
| pinOut | output | NUM_PORTS·PORT_W | Output values |
| pinOe | output | NUM_PORTS·PORT_W | Per-pin output enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle: an edge can latch only on a pin that was enabled for edge sensing, `irqOut` is never raised without an enabled unmasked pin, and `pinOe` moves only after a direction write. They also check that the acknowledge register reads zero and that a debounced pin changes its accepted value only after a tick. The exact cycle at which level and edge interrupts appear and are cleared, and the restart of the debounce count after a glitch, are shown by the scenarios. The same applies to the alternate register layout and to the isolation of the second port. In these scenarios a behavioural model is compared against the design on every clock.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int ADDR_W     = 8;
  localparam int PORT_SEL_W = 2;   // up to four ports

  // per-port register placement
  localparam logic [7:0] OFF_DATA0   = 8'h00;
  localparam logic [7:0] OFF_DIR0    = 8'h04;
  localparam int         PORT_STRIDE = 12;
  localparam logic [7:0] OFF_EXT0    = 8'h50;
  localparam int         EXT_STRIDE  = 4;

  // interrupt registers, default placement
  localparam logic [7:0] OFF_EN      = 8'h30;
  localparam logic [7:0] OFF_DEB     = 8'h48;
  localparam logic [7:0] DEF_MASK    = 8'h34;
  localparam logic [7:0] DEF_TYPE    = 8'h38;
  localparam logic [7:0] DEF_POL     = 8'h3C;
  localparam logic [7:0] DEF_STAT    = 8'h40;
  localparam logic [7:0] DEF_ACK     = 8'h4C;
  // alternate placement
  localparam logic [7:0] ALT_MASK    = 8'h44;
  localparam logic [7:0] ALT_TYPE    = 8'h34;
  localparam logic [7:0] ALT_POL     = 8'h38;
  localparam logic [7:0] ALT_STAT    = 8'h3C;
  localparam logic [7:0] ALT_ACK     = 8'h40;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_EXT, RD_EN,
    RD_MASK, RD_TYPE, RD_POL, RD_STAT, RD_DEB
  } rdSel_e;

  typedef struct packed {
    logic                  wrData;
    logic                  wrDir;
    logic                  wrEn;
    logic                  wrMask;
    logic                  wrType;
    logic                  wrPol;
    logic                  wrDeb;
    logic                  wrAck;
    logic [PORT_SEL_W-1:0] port;
    rdSel_e                rdSel;
  } regStrobe_t;
endpackage

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              altLayout,
  output regStrobe_t        strobe
);
  logic       wrAct;
  logic       rdAct;
  logic [7:0] maskAddr, typeAddr, polAddr, statAddr, ackAddr;

  assign wrAct = psel & penable & pwrite;
  assign rdAct = psel & ~pwrite;

  assign maskAddr = altLayout ? ALT_MASK : DEF_MASK;
  assign typeAddr = altLayout ? ALT_TYPE : DEF_TYPE;
  assign polAddr  = altLayout ? ALT_POL  : DEF_POL;
  assign statAddr = altLayout ? ALT_STAT : DEF_STAT;
  assign ackAddr  = altLayout ? ALT_ACK  : DEF_ACK;

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (paddr == OFF_DATA0 + 8'(k * PORT_STRIDE)) begin
        strobe.port   = PORT_SEL_W'(k);
        strobe.wrData = wrAct;
        if (rdAct) strobe.rdSel = RD_DATA;
      end
      if (paddr == OFF_DIR0 + 8'(k * PORT_STRIDE)) begin
        strobe.port  = PORT_SEL_W'(k);
        strobe.wrDir = wrAct;
        if (rdAct) strobe.rdSel = RD_DIR;
      end
      if (paddr == OFF_EXT0 + 8'(k * EXT_STRIDE)) begin
        strobe.port = PORT_SEL_W'(k);
        if (rdAct) strobe.rdSel = RD_EXT;
      end
    end
    if (paddr == OFF_EN) begin
      strobe.wrEn = wrAct;
      if (rdAct) strobe.rdSel = RD_EN;
    end
    if (paddr == OFF_DEB) begin
      strobe.wrDeb = wrAct;
      if (rdAct) strobe.rdSel = RD_DEB;
    end
    if (paddr == maskAddr) begin
      strobe.wrMask = wrAct;
      if (rdAct) strobe.rdSel = RD_MASK;
    end
    if (paddr == typeAddr) begin
      strobe.wrType = wrAct;
      if (rdAct) strobe.rdSel = RD_TYPE;
    end
    if (paddr == polAddr) begin
      strobe.wrPol = wrAct;
      if (rdAct) strobe.rdSel = RD_POL;
    end
    if (paddr == statAddr) begin
      if (rdAct) strobe.rdSel = RD_STAT;
    end
    if (paddr == ackAddr) begin
      strobe.wrAck = wrAct;   // reads fall through as zero
    end
  end
endmodule

// File: rtl/pb_datapath.sv
module pb_datapath
  import pb_pkg::*;
#(
  parameter int PORT_W    = 32,
  parameter int NUM_PORTS = 2,
  parameter int DEB_TICKS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regStrobe_t                  strobe,
  input  logic [PORT_W-1:0]           pwdata,
  output logic [PORT_W-1:0]           prdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  input  logic                        dbTick,
  output logic [NUM_PORTS*PORT_W-1:0] pinOut,
  output logic [NUM_PORTS*PORT_W-1:0] pinOe,
  output logic                        irqOut
);
  localparam int TOTAL_W = NUM_PORTS * PORT_W;
  localparam int CNT_W   = $clog2(DEB_TICKS + 1);

  logic [TOTAL_W-1:0] dataFlat, dirFlat;
  logic [TOTAL_W-1:0] syncA, syncB;
  logic [PORT_W-1:0]  intEn, intMask, intType, intPol, debEn;
  logic [PORT_W-1:0]  edgeLatch, filtPrev, filt;
  logic [PORT_W-1:0]  levelHit, edgeHit, ackClr, pending, status;

  // port output and direction registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataFlat <= '0;
      dirFlat  <= '0;
    end else begin
      for (int k = 0; k < NUM_PORTS; k++) begin
        if (strobe.port == PORT_SEL_W'(k)) begin
          if (strobe.wrData) dataFlat[k*PORT_W +: PORT_W] <= pwdata;
          if (strobe.wrDir)  dirFlat[k*PORT_W +: PORT_W]  <= pwdata;
        end
      end
    end
  end
  assign pinOut = dataFlat;
  assign pinOe  = dirFlat;

  // two-flop input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // first-port interrupt configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn   <= '0;
      intMask <= '0;
      intType <= '0;
      intPol  <= '0;
      debEn   <= '0;
    end else begin
      if (strobe.wrEn)   intEn   <= pwdata;
      if (strobe.wrMask) intMask <= pwdata;
      if (strobe.wrType) intType <= pwdata;
      if (strobe.wrPol)  intPol  <= pwdata;
      if (strobe.wrDeb)  debEn   <= pwdata;
    end
  end

  // per-bit debounce filter, first port only
  for (genvar b = 0; b < PORT_W; b++) begin : g_deb
    logic [CNT_W-1:0] cnt;
    logic             held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        held <= 1'b0;
      end else if (!debEn[b] || syncB[b] == held) begin
        cnt  <= '0;
        held <= syncB[b];
      end else if (dbTick) begin
        if (cnt == CNT_W'(DEB_TICKS - 1)) begin
          held <= syncB[b];
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[b] = debEn[b] ? held : syncB[b];
  end

  // interrupt detection
  assign levelHit = ~(filt ^ intPol);
  assign edgeHit  = (filt & ~filtPrev & intPol) | (~filt & filtPrev & ~intPol);
  assign ackClr   = strobe.wrAck ? pwdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtPrev  <= '0;
      edgeLatch <= '0;
    end else begin
      filtPrev  <= filt;
      edgeLatch <= (edgeLatch & ~ackClr) | (edgeHit & intEn & intType);
    end
  end

  assign pending = (intType & edgeLatch) | (~intType & levelHit);
  assign status  = pending & intEn & ~intMask;
  assign irqOut  = |status;

  // read mux
  always_comb begin
    prdata = '0;
    case (strobe.rdSel)
      RD_DATA, RD_DIR, RD_EXT: begin
        for (int k = 0; k < NUM_PORTS; k++) begin
          if (strobe.port == PORT_SEL_W'(k)) begin
            if (strobe.rdSel == RD_DATA)     prdata = dataFlat[k*PORT_W +: PORT_W];
            else if (strobe.rdSel == RD_DIR) prdata = dirFlat[k*PORT_W +: PORT_W];
            else                             prdata = syncB[k*PORT_W +: PORT_W];
          end
        end
      end
      RD_EN:   prdata = intEn;
      RD_MASK: prdata = intMask;
      RD_TYPE: prdata = intType;
      RD_POL:  prdata = intPol;
      RD_STAT: prdata = status;
      RD_DEB:  prdata = debEn;
      default: prdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_bank_apb.sv
module pin_bank_apb
  import pb_pkg::*;
#(
  parameter int PORT_W    = 32,
  parameter int NUM_PORTS = 2,
  parameter int DEB_TICKS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        altLayout,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [PORT_W-1:0]           pwdata,
  output logic [PORT_W-1:0]           prdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  input  logic                        dbTick,
  output logic [NUM_PORTS*PORT_W-1:0] pinOut,
  output logic [NUM_PORTS*PORT_W-1:0] pinOe,
  output logic                        irqOut
);
  regStrobe_t strobe;

  pb_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .altLayout(altLayout), .strobe(strobe)
  );

  pb_datapath #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .DEB_TICKS(DEB_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwdata(pwdata), .prdata(prdata),
    .pinIn(pinIn), .dbTick(dbTick), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int W  = 32,
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          altLayout,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [7:0]    paddr,
  input logic [W-1:0]  prdata,
  input logic          dbTick,
  input logic [NP*W-1:0] pinOe,
  input logic          irqOut,
  input logic [W-1:0]  intEn,
  input logic [W-1:0]  intMask,
  input logic [W-1:0]  intType,
  input logic [W-1:0]  debEn,
  input logic [W-1:0]  edgeLatch,
  input logic [W-1:0]  filt
);
  function automatic logic isDirAddr(input logic [7:0] a);
    for (int k = 0; k < NP; k++)
      if (a == 8'(k * 12 + 4)) return 1'b1;
    return 1'b0;
  endfunction

  logic dirWrite;
  logic [7:0] ackAddr;
  assign dirWrite = psel & penable & pwrite & isDirAddr(paddr);
  assign ackAddr  = altLayout ? 8'h40 : 8'h4C;

  // R1: quiet outputs while in reset
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (pinOe == '0 && !irqOut);
    end
  end

  // R2: output enables move only after a direction write
  assert_dir_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !dirWrite |=> $stable(pinOe));

  // R5: a new latched edge needs enable and edge type in the cycle before
  assert_edge_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeLatch & ~$past(edgeLatch) & ~$past(intEn & intType)) == '0));

  // R6: no interrupt without an enabled unmasked pin
  assert_mask_gates_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((intEn & ~intMask) != '0));

  // R7: acknowledge register reads zero
  assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !pwrite && paddr == ackAddr) |-> (prdata == '0));

  // R9: a debounced pin changes its accepted value only on a tick
  assert_debounce_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dbTick |=> (((filt ^ $past(filt)) & $past(debEn) & debEn) == '0));
endmodule

bind pin_bank_apb pb_checker #(.W(PORT_W), .NP(NUM_PORTS)) chk_i (
  .clk(clk), .rstN(rstN), .altLayout(altLayout), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .dbTick(dbTick), .pinOe(pinOe),
  .irqOut(irqOut), .intEn(dp_i.intEn), .intMask(dp_i.intMask), .intType(dp_i.intType),
  .debEn(dp_i.debEn), .edgeLatch(dp_i.edgeLatch), .filt(dp_i.filt)
);

// File: tb/pin_bank_apb_tb_top.sv
`timescale 1ns/1ps
module pin_bank_apb_tb_top;
  localparam int W   = 32;
  localparam int NP  = 2;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic altLayout = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [W-1:0] pwdata = '0;
  logic [W-1:0] prdata;
  logic [NP*W-1:0] pinIn = '0;
  logic dbTick = 1'b0;
  logic [NP*W-1:0] pinOut, pinOe;
  logic irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pin_bank_apb #(.PORT_W(W), .NUM_PORTS(NP), .DEB_TICKS(DEB)) dut_i (
    .clk(clk), .rstN(rstN), .altLayout(altLayout), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pinIn(pinIn),
    .dbTick(dbTick), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] mData [NP];
  logic [W-1:0] mDir  [NP];
  logic [W-1:0] mEn, mMask, mType, mPol, mDeb, mLatch, mPrev, mHeld;
  logic [NP*W-1:0] mS1, mS2;
  int mCnt [W];

  function automatic logic [W-1:0] mFilt();
    logic [W-1:0] f;
    for (int b = 0; b < W; b++) f[b] = mDeb[b] ? mHeld[b] : mS2[b];
    return f;
  endfunction

  function automatic logic [W-1:0] mStatus();
    logic [W-1:0] f, s;
    f = mFilt();
    for (int b = 0; b < W; b++) begin
      logic p;
      if (mType[b]) p = mLatch[b];
      else p = mPol[b] ? f[b] : !f[b];
      s[b] = p && mEn[b] && !mMask[b];
    end
    return s;
  endfunction

  function automatic logic [W-1:0] mRead(input logic [7:0] a);
    int ia;
    ia = int'(a);
    for (int k = 0; k < NP; k++) begin
      if (ia == 12 * k)     return mData[k];
      if (ia == 12 * k + 4) return mDir[k];
      if (ia == 80 + 4 * k) return mS2[k*W +: W];
    end
    if (ia == 'h30) return mEn;
    if (ia == 'h48) return mDeb;
    if (ia == (altLayout ? 'h44 : 'h34)) return mMask;
    if (ia == (altLayout ? 'h34 : 'h38)) return mType;
    if (ia == (altLayout ? 'h38 : 'h3C)) return mPol;
    if (ia == (altLayout ? 'h3C : 'h40)) return mStatus();
    return '0;
  endfunction

  always @(posedge clk or negedge rstN) begin : model_step
    logic [W-1:0] f, ev, ack;
    logic wr;
    int ia;
    if (!rstN) begin
      for (int k = 0; k < NP; k++) begin mData[k] <= '0; mDir[k] <= '0; end
      mEn <= '0; mMask <= '0; mType <= '0; mPol <= '0; mDeb <= '0;
      mLatch <= '0; mPrev <= '0; mHeld <= '0; mS1 <= '0; mS2 <= '0;
      for (int b = 0; b < W; b++) mCnt[b] <= 0;
    end else begin
      wr = psel && penable && pwrite;
      ia = int'(paddr);
      f = mFilt();
      ack = '0;
      if (wr) begin
        for (int k = 0; k < NP; k++) begin
          if (ia == 12 * k)     mData[k] <= pwdata;
          if (ia == 12 * k + 4) mDir[k]  <= pwdata;
        end
        if (ia == 'h30) mEn <= pwdata;
        if (ia == 'h48) mDeb <= pwdata;
        if (ia == (altLayout ? 'h44 : 'h34)) mMask <= pwdata;
        if (ia == (altLayout ? 'h34 : 'h38)) mType <= pwdata;
        if (ia == (altLayout ? 'h38 : 'h3C)) mPol <= pwdata;
        if (ia == (altLayout ? 'h40 : 'h4C)) ack = pwdata;
      end
      for (int b = 0; b < W; b++) begin
        ev[b] = mPol[b] ? (f[b] && !mPrev[b]) : (!f[b] && mPrev[b]);
        if (!mDeb[b] || mS2[b] == mHeld[b]) begin
          mCnt[b] <= 0;
          mHeld[b] <= mS2[b];
        end else if (dbTick) begin
          if (mCnt[b] == DEB - 1) begin mHeld[b] <= mS2[b]; mCnt[b] <= 0; end
          else mCnt[b] <= mCnt[b] + 1;
        end
      end
      mLatch <= (mLatch & ~ack) | (ev & mEn & mType);
      mPrev <= f;
      mS1 <= pinIn;
      mS2 <= mS1;
    end
  end

  // lockstep comparison on every clock
  always @(negedge clk) begin
    if (running) begin
      #1;
      chk("R2 pinOut vs model", 64'(pinOut), 64'({mData[1], mData[0]}));
      chk("R2 pinOe vs model", 64'(pinOe), 64'({mDir[1], mDir[0]}));
      chk("R8 irqOut vs model", 64'(irqOut), 64'(|mStatus()));
      if (psel && !pwrite) chk("R10 prdata vs model", 64'(prdata), 64'(mRead(paddr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic apbWr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #2;
  endtask

  task automatic apbRd(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #2 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    #2;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [W-1:0] exp);
    logic [W-1:0] d;
    apbRd(a, d);
    chk(tag, 64'(d), 64'(exp));
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic tick();
    @(negedge clk);
    dbTick = 1'b1;
    @(negedge clk);
    dbTick = 1'b0;
    #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    running = 1'b1;
    waitCyc(1);

    // R1 reset state
    chk("R1 irqOut after reset", 64'(irqOut), 64'd0);
    chk("R1 pinOe after reset", 64'(pinOe), 64'd0);
    rdChk("R1 data0 reset", 8'h00, 32'h0);
    rdChk("R1 dir0 reset", 8'h04, 32'h0);
    rdChk("R1 enable reset", 8'h30, 32'h0);
    rdChk("R1 status reset", 8'h40, 32'h0);

    // R2 data and direction per port
    apbWr(8'h00, 32'hA5A5_0F0F);
    apbWr(8'h04, 32'hFFFF_0000);
    apbWr(8'h0C, 32'h1234_5678);
    apbWr(8'h10, 32'hFFFF_FFFF);
    chk("R2 pinOut both ports", 64'(pinOut), 64'h1234_5678_A5A5_0F0F);
    chk("R2 pinOe both ports", 64'(pinOe), 64'hFFFF_FFFF_FFFF_0000);
    rdChk("R2 data1 readback", 8'h0C, 32'h1234_5678);

    // R3 synchronised input registers
    pinIn = {32'hDEAD_BEEF, 32'h0000_00C3};
    waitCyc(3);
    rdChk("R3 ext port0", 8'h50, 32'h0000_00C3);
    rdChk("R3 ext port1", 8'h54, 32'hDEAD_BEEF);

    // R4 level sensing
    apbWr(8'h38, 32'h0);
    apbWr(8'h3C, 32'h1);
    apbWr(8'h30, 32'h1);
    chk("R4 level high active", 64'(irqOut), 64'd1);
    rdChk("R8 status level bit0", 8'h40, 32'h1);
    pinIn[0] = 1'b0;
    waitCyc(3);
    chk("R4 level follows pin, not latched", 64'(irqOut), 64'd0);
    apbWr(8'h3C, 32'h0);
    chk("R4 level low active", 64'(irqOut), 64'd1);

    // R5 rising edge
    apbWr(8'h30, 32'h0);
    apbWr(8'h38, 32'h10);
    apbWr(8'h3C, 32'h10);
    apbWr(8'h4C, 32'hFFFF_FFFF);
    apbWr(8'h30, 32'h10);
    chk("R5 no event yet", 64'(irqOut), 64'd0);
    pinIn[4] = 1'b1;
    waitCyc(4);
    chk("R5 rising edge raises irq", 64'(irqOut), 64'd1);
    pinIn[4] = 1'b0;
    waitCyc(4);
    chk("R5 edge stays latched", 64'(irqOut), 64'd1);
    rdChk("R8 status edge bit4", 8'h40, 32'h10);

    // R7 acknowledge
    apbWr(8'h4C, 32'h20);
    chk("R7 zero bit leaves latch", 64'(irqOut), 64'd1);
    rdChk("R7 ack reads zero", 8'h4C, 32'h0);
    apbWr(8'h4C, 32'h10);
    chk("R7 ack clears latch", 64'(irqOut), 64'd0);

    // R5 falling edge
    apbWr(8'h3C, 32'h0);
    pinIn[4] = 1'b1;
    waitCyc(4);
    chk("R5 rising ignored in falling mode", 64'(irqOut), 64'd0);
    pinIn[4] = 1'b0;
    waitCyc(4);
    chk("R5 falling edge raises irq", 64'(irqOut), 64'd1);

    // R6 mask
    apbWr(8'h34, 32'h10);
    chk("R6 mask hides irq", 64'(irqOut), 64'd0);
    rdChk("R6 mask hides status", 8'h40, 32'h0);
    apbWr(8'h34, 32'h0);
    chk("R6 unmask shows kept latch", 64'(irqOut), 64'd1);
    apbWr(8'h4C, 32'hFFFF_FFFF);
    chk("R7 ack all clears", 64'(irqOut), 64'd0);

    // R5 disabled pin does not latch
    apbWr(8'h30, 32'h0);
    pinIn[4] = 1'b1;
    waitCyc(4);
    pinIn[4] = 1'b0;
    waitCyc(4);
    apbWr(8'h30, 32'h10);
    chk("R5 edge while disabled not latched", 64'(irqOut), 64'd0);

    // R11 second port isolated
    apbWr(8'h30, 32'h0);
    apbWr(8'h4C, 32'hFFFF_FFFF);
    apbWr(8'h38, 32'hFFFF_FFFF);
    apbWr(8'h3C, 32'hFFFF_FFFF);
    apbWr(8'h30, 32'hFFFF_FFFF);
    pinIn[63:32] = 32'h0F0F_0F0F;
    waitCyc(4);
    pinIn[63:32] = 32'h0;
    waitCyc(4);
    chk("R11 port1 pins no irq", 64'(irqOut), 64'd0);
    apbWr(8'h30, 32'h0);

    // R9 debounce
    apbWr(8'h38, 32'h0);
    apbWr(8'h48, 32'h100);
    apbWr(8'h30, 32'h100);
    chk("R9 debounced pin idle", 64'(irqOut), 64'd0);
    pinIn[8] = 1'b1;
    waitCyc(3);
    tick(); tick(); tick();
    chk("R9 three ticks not enough", 64'(irqOut), 64'd0);
    pinIn[8] = 1'b0;
    waitCyc(3);
    pinIn[8] = 1'b1;
    waitCyc(3);
    tick(); tick(); tick();
    chk("R9 glitch restarted count", 64'(irqOut), 64'd0);
    tick();
    chk("R9 accepted after full count", 64'(irqOut), 64'd1);

    // R10 alternate layout
    apbWr(8'h30, 32'h0);
    altLayout = 1'b1;
    waitCyc(1);
    apbWr(8'h34, 32'h5);
    rdChk("R10 alt type at 0x34", 8'h34, 32'h5);
    rdChk("R10 alt polarity at 0x38", 8'h38, 32'hFFFF_FFFF);
    apbWr(8'h44, 32'h3);
    rdChk("R10 alt mask at 0x44", 8'h44, 32'h3);
    rdChk("R10 debounce unchanged", 8'h48, 32'h100);
    apbWr(8'h34, 32'h0);
    apbWr(8'h44, 32'h0);
    apbWr(8'h30, 32'h2);
    chk("R10 level irq in alt layout", 64'(irqOut), 64'd1);
    rdChk("R10 alt status at 0x3C", 8'h3C, 32'h2);
    rdChk("R10 alt ack at 0x40 reads zero", 8'h40, 32'h0);
    apbWr(8'h44, 32'h2);
    chk("R10 alt mask effective", 64'(irqOut), 64'd0);

    waitCyc(2);
    running = 1'b0;
    summary();
    $finish;
  end
endmodule